// File: doc/BRIEF.md
# Feedback-Gated Dead-Time Sequencer

This block turns one PWM command into two gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. The two enables are never on together. Dead time is not a fixed delay. Every turn-on waits for evidence that the opposite switch has really turned off, and that evidence comes from two digitized comparator inputs.

Before the high side may turn on, the sensed low-side gate voltage must read low. Before the low side may turn on, the switch node must read low. When the inductor current is negative, the switch node may never fall after the high side is released. For that case a watchdog turns the low side on after a fixed number of cycles, so the current can recirculate.

A duty limiter caps each high-side pulse at a parameterized fraction of the switching period. A global run input forces both gates off within one clock. A low-side block input keeps the low-side gate off without disturbing the high-side handshake.

Top module: `gate_handoff_seq`

## Requirements
- R1: After reset, hs_gate and ls_gate are both 0. With run_en high, they stay 0 until pwm_cmd is first seen high.
- R2: hs_gate and ls_gate are never 1 in the same cycle.
- R3: Once pwm_cmd is seen high, hs_gate stays 0 while lsg_low is 0. hs_gate goes to 1 on the clock edge that samples lsg_low = 1.
- R4: When pwm_cmd falls during a high-side pulse:
  - hs_gate drops on the next edge.
  - Both gates then stay 0 until sw_low is sampled as 1.
  - ls_gate rises on that edge.
- R5: If sw_low stays 0 after hs_gate drops, both gates stay 0 for exactly WDOG_CYCLES cycles (default 8). ls_gate rises on the following edge.
- R6: A high-side pulse lasts at most MAX_HS = PERIOD_CYCLES*MAX_DUTY_PCT/100 consecutive cycles (16 with the defaults 20 and 80). After that the pulse ends and the low-side handoff of R4/R5 follows, even if pwm_cmd is still high.
- R7: After a pulse has been cut by R6, hs_gate is not raised again until pwm_cmd has been seen low at least once.
- R8: run_en low forces both gates to 0 on the next edge, from any state. After run_en returns high, a new high-side pulse again waits for lsg_low as in R3.
- R9: While ls_block is 1, ls_gate is 0. The high-side handshake works as it does without the block. Once the block is released during the low-side phase, ls_gate rises on the next edge.
- R10: If pwm_cmd falls while the sequencer waits for lsg_low, no high-side pulse is produced. The sequencer goes straight to the low-side handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_cmd | input | 1 | PWM command; 1 requests the high side |
| sw_low | input | 1 | Switch node sensed below its threshold |
| lsg_low | input | 1 | Low-side gate voltage sensed below its threshold |
| run_en | input | 1 | Global enable; 0 forces both gates off |
| ls_block | input | 1 | 1 holds the low-side gate off |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The hardest condition to reach from the ports is the duty cap followed by re-arming. It needs pwm_cmd and lsg_low held high for more than MAX_HS cycles. Then pwm_cmd must stay high after the cut, to show that the high side does not come back, and must finally drop for a single cycle to re-arm.

The watchdog path is reached by keeping sw_low at 0 after the high side is released. The bench counts the exact number of cycles with both gates off.

A scoreboard queue takes one expected pair of gate values per clock edge, tagged with its requirement. An overlap monitor runs on every cycle for the whole test.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_HS_ON     = 3'd1,
      ST_WAIT_SW   = 3'd2,
      ST_LS_ON     = 3'd3,
      ST_WAIT_LSG  = 3'd4
   } seq_state_t;

   function automatic int unsigned cap_cycles(input int unsigned period,
                                              input int unsigned pct);
      return (period * pct) / 100;
   endfunction

endpackage

// File: rtl/gate_span_timer.sv
module gate_span_timer #(
   parameter int unsigned LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT <= 1) begin : g_single
         assign done = run;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               cnt <= '0;
            end else if (cnt != LAST) begin
               cnt <= cnt + 1'b1;
            end
         end

         assign done = run && (cnt == LAST);

         AST_TIMER_STOPS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            (run && done) |=> (!run || done)); // R5
      end
   endgenerate

endmodule

// File: rtl/gate_seq_core.sv
module gate_seq_core
   import gate_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_cmd,
   input  logic       sw_low,
   input  logic       lsg_low,
   input  logic       run_en,
   input  logic       wd_done,
   input  logic       cap_done,
   output seq_state_t state
);
   seq_state_t nxt;
   logic       armed;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (pwm_cmd && armed) nxt = ST_WAIT_LSG;
         end
         ST_WAIT_LSG: begin
            if (!pwm_cmd)     nxt = ST_WAIT_SW;
            else if (lsg_low) nxt = ST_HS_ON;
         end
         ST_HS_ON: begin
            if (!pwm_cmd || cap_done) nxt = ST_WAIT_SW;
         end
         ST_WAIT_SW: begin
            if (sw_low || wd_done) nxt = ST_LS_ON;
         end
         ST_LS_ON: begin
            if (pwm_cmd && armed) nxt = ST_WAIT_LSG;
         end
         default: nxt = ST_IDLE;
      endcase
      if (!run_en) nxt = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         armed <= 1'b1;
      end else begin
         state <= nxt;
         if (!pwm_cmd) begin
            armed <= 1'b1;
         end else if (state == ST_HS_ON && cap_done) begin
            armed <= 1'b0;
         end
      end
   end

   AST_HS_ENTRY_NEEDS_LSG: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_HS_ON) ##1 (state == ST_HS_ON) |-> $past(lsg_low)); // R3

   AST_LS_ENTRY_NEEDS_PROOF: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_SW) ##1 (state == ST_LS_ON) |-> ($past(sw_low) || $past(wd_done))); // R4

   AST_NO_REARM_AFTER_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HS_ON && cap_done && pwm_cmd) |=> (state != ST_HS_ON)); // R7

endmodule

// File: rtl/gate_handoff_seq.sv
module gate_handoff_seq
   import gate_seq_pkg::*;
#(
   parameter int unsigned PERIOD_CYCLES = 20,
   parameter int unsigned MAX_DUTY_PCT  = 80,
   parameter int unsigned WDOG_CYCLES   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_cmd,
   input  logic sw_low,
   input  logic lsg_low,
   input  logic run_en,
   input  logic ls_block,
   output logic hs_gate,
   output logic ls_gate
);
   localparam int unsigned MAX_HS = cap_cycles(PERIOD_CYCLES, MAX_DUTY_PCT);

   generate
      if (MAX_DUTY_PCT == 0 || MAX_DUTY_PCT > 100) begin : g_bad_pct
         $error("MAX_DUTY_PCT must lie in 1..100");
      end
      if (MAX_HS < 1) begin : g_bad_cap
         $error("PERIOD_CYCLES*MAX_DUTY_PCT/100 must be at least 1");
      end
      if (WDOG_CYCLES < 1) begin : g_bad_wd
         $error("WDOG_CYCLES must be at least 1");
      end
   endgenerate

   seq_state_t state;
   logic       wd_done;
   logic       cap_done;

   gate_span_timer #(.LIMIT(WDOG_CYCLES)) u_wdog (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_WAIT_SW),
      .done  (wd_done)
   );

   gate_span_timer #(.LIMIT(MAX_HS)) u_duty (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_HS_ON),
      .done  (cap_done)
   );

   gate_seq_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_cmd  (pwm_cmd),
      .sw_low   (sw_low),
      .lsg_low  (lsg_low),
      .run_en   (run_en),
      .wd_done  (wd_done),
      .cap_done (cap_done),
      .state    (state)
   );

   assign hs_gate = (state == ST_HS_ON);
   assign ls_gate = (state == ST_LS_ON) && !ls_block;

   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate)); // R2

   AST_DISABLE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!hs_gate && !ls_gate)); // R8

   AST_DUTY_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_gate && cap_done) |=> !hs_gate); // R6

   AST_HS_FALL_HANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_gate) |-> !ls_gate); // R4

endmodule

// File: tb/tb_gate_handoff_seq.sv
module tb_gate_handoff_seq;

   typedef struct {
      bit    hs;
      bit    ls;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_cmd = 1'b0, sw_low = 1'b0, lsg_low = 1'b1, run_en = 1'b1, ls_block = 1'b0;
   logic hs_gate, ls_gate;

   int   checks = 0;
   int   failures = 0;
   int   overlap_cnt = 0;
   bit   done_flag = 0;
   exp_t sb[$];

   always #2 clk = ~clk;

   gate_handoff_seq dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_cmd  (pwm_cmd),
      .sw_low   (sw_low),
      .lsg_low  (lsg_low),
      .run_en   (run_en),
      .ls_block (ls_block),
      .hs_gate  (hs_gate),
      .ls_gate  (ls_gate)
   );

   // monitor: pops one expectation per edge, samples 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && hs_gate && ls_gate) overlap_cnt++;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (hs_gate !== e.hs || ls_gate !== e.ls) begin
            failures++;
            $display("FAIL %s: hs/ls actual=%b%b expected=%b%b at %0t",
                     e.tag, hs_gate, ls_gate, e.hs, e.ls, $time);
         end
      end
   end

   task automatic step(input bit hs, input bit ls, input string tag);
      exp_t e;
      e.hs = hs; e.ls = ls; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, idle without command
      step(0, 0, "R1");
      step(0, 0, "R1");

      // R3 / R4: normal cycle
      pwm_cmd = 1; lsg_low = 0;
      step(0, 0, "R3");
      step(0, 0, "R3");
      step(0, 0, "R3");
      lsg_low = 1;
      step(1, 0, "R3");
      lsg_low = 0;
      step(1, 0, "R3");
      pwm_cmd = 0;
      step(0, 0, "R4");
      step(0, 0, "R4");
      sw_low = 1;
      step(0, 1, "R4");

      // R5: watchdog when switch node never falls
      pwm_cmd = 1; sw_low = 0; lsg_low = 0;
      step(0, 0, "R3");
      lsg_low = 1;
      step(1, 0, "R3");
      pwm_cmd = 0; lsg_low = 0;
      for (int i = 0; i < 8; i++) step(0, 0, "R5");
      step(0, 1, "R5");

      // R6 / R7: duty cap and re-arm
      pwm_cmd = 1; lsg_low = 1; sw_low = 1;
      step(0, 0, "R6");
      for (int i = 0; i < 16; i++) step(1, 0, "R6");
      step(0, 0, "R6");
      step(0, 1, "R6");
      for (int i = 0; i < 3; i++) step(0, 1, "R7");
      pwm_cmd = 0;
      step(0, 1, "R7");
      pwm_cmd = 1;
      step(0, 0, "R7");
      step(1, 0, "R7");

      // R9: low-side block
      ls_block = 1; pwm_cmd = 0; sw_low = 1;
      step(0, 0, "R9");
      step(0, 0, "R9");
      step(0, 0, "R9");
      pwm_cmd = 1; lsg_low = 0;
      step(0, 0, "R9");
      lsg_low = 1;
      step(1, 0, "R9");
      pwm_cmd = 0;
      step(0, 0, "R9");
      step(0, 0, "R9");
      ls_block = 0;
      step(0, 1, "R9");

      // R8: global enable
      pwm_cmd = 1;
      step(0, 0, "R8");
      step(1, 0, "R8");
      run_en = 0;
      step(0, 0, "R8");
      pwm_cmd = 0;
      step(0, 0, "R8");
      pwm_cmd = 1;
      step(0, 0, "R8");
      run_en = 1; lsg_low = 0;
      step(0, 0, "R8");
      step(0, 0, "R8");
      lsg_low = 1;
      step(1, 0, "R8");
      pwm_cmd = 0; sw_low = 1;
      step(0, 0, "R8");
      step(0, 1, "R8");
      run_en = 0;
      step(0, 0, "R8");
      run_en = 1;
      step(0, 0, "R8");
      step(0, 0, "R1");

      // R10: command withdrawn while waiting for low-side gate
      pwm_cmd = 1; lsg_low = 0; sw_low = 0;
      step(0, 0, "R10");
      pwm_cmd = 0;
      step(0, 0, "R10");
      sw_low = 1;
      step(0, 1, "R10");
      step(0, 1, "R10");

      @(negedge clk);
      // R2: overlap seen over the whole run
      checks++;
      if (overlap_cnt != 0) begin
         failures++;
         $display("FAIL R2: overlap cycles actual=%0d expected=0", overlap_cnt);
      end
      done_flag = 1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule